// File: doc/BRIEF.md
# Floppy Drive Control Delay Generator

This block times the three drive-control delays that a floppy disk controller needs. The first is the spacing of head step pulses during a seek. The second is the settle time after the head is loaded. The third is the idle timeout after which a loaded head is released. Each delay comes from a small code and a time unit, and the unit depends on the selected data rate. The codes are written through a three-field load port when a drive-parameter command is decoded elsewhere.

Three requests drive the block. A seek request gives a step count. A head-load request precedes a read or write. An end-of-execution event marks the end of a read or write. In return the block emits step pulses, a seek-done strobe, a head-loaded level, a strobe when the head has settled, and a strobe when the idle timeout drops the head. A polling-inhibit level tells the drive poller to stay quiet while the head is held.

All timing is counted in system clocks. One base tick is `CLK_PER_QMS` clocks and stands for a quarter millisecond. Delays that are not whole quarter-milliseconds at the 300 kb/s rate are rounded to fixed tick counts.

Top module: `fdd_delay_timer`

## Requirements
- R1: After reset the head is unloaded, every output is low, and all three codes read zero. Zero codes select the longest delays.
- R2: The codes are captured on a clock edge where `specWr` is high. A timer uses the codes and `rateSel` present on the edge it starts. Writing new codes while a timer runs does not change that timer.
- R3: Rate encoding for `rateSel`: 0 = 2 Mb/s, 1 = 1 Mb/s, 2 = 500 kb/s, 3 = 300 kb/s, 4 to 7 = 250 kb/s. The step unit is 1, 2, 4, 7 or 8 ticks. The load unit is 2, 4, 8, 13 or 16 ticks. The unload unit is 16, 32, 64, 107 or 128 ticks. Each list follows the rate order above.
- R4: An accepted seek of N > 0 steps raises `stepOut` on the cycle after the request. Pulses start every (16 − step code) × step unit × `CLK_PER_QMS` clocks, and exactly N pulses are sent.
- R5: Each step pulse is high for exactly `PULSE_W` clocks.
- R6: `seekBusy` is high during a seek. `seekDone` pulses for one cycle one full step interval after the last pulse starts, and `seekBusy` falls on that same edge. A seek of zero steps gives `seekDone` on the next cycle with no pulse.
- R7: A seek request while `seekBusy` is high is ignored.
- R8: A load request on an unloaded head raises `headLoaded` on the next cycle. `loadDone` follows exactly L × load unit × `CLK_PER_QMS` clocks later, where L is the load code (7 bits) and code 0 means 128.
- R9: `execEnd` on a settled, loaded head starts the unload timeout. After U × unload unit × `CLK_PER_QMS` clocks, where U is the 4-bit unload code and code 0 means 16, `unloadExpired` pulses and `headLoaded` falls on the same edge. Another `execEnd` during the timeout restarts it.
- R10: A load request on a settled, loaded head gives `loadDone` on the next cycle. If the unload timeout is running, that request also cancels it, and the head stays loaded with no further delay.
- R11: `pollInhibit` is high exactly while `headLoaded` is high.
- R12: `execEnd` on an unloaded or still-settling head is ignored. A second load request during settling does not move `loadDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rateSel | input | 3 | Data-rate select (R3 encoding) |
| specWr | input | 1 | Capture the three codes |
| specSrt | input | 4 | Step interval code |
| specHut | input | 4 | Unload timeout code |
| specHlt | input | 7 | Head settle code |
| seekReq | input | 1 | Start a seek |
| seekSteps | input | STEPS_W | Number of steps for the seek |
| loadReq | input | 1 | Request a loaded, settled head |
| execEnd | input | 1 | End of a read/write execution phase |
| stepOut | output | 1 | Step pulse to the drive |
| seekBusy | output | 1 | Seek in progress |
| seekDone | output | 1 | One-cycle seek completion strobe |
| headLoaded | output | 1 | Head-load level to the drive |
| loadDone | output | 1 | One-cycle strobe: head settled |
| unloadExpired | output | 1 | One-cycle strobe: idle timeout dropped the head |
| pollInhibit | output | 1 | Suppress drive polling |

## Verification
A wrong count load or a wrong rate unit shows up as a strobe on the wrong cycle. The bench measures every delay to the exact clock, so an error of one clock in any timer is caught on the first delay that uses it. A head state machine that slips shows up as `headLoaded` falling early, or as a stray `unloadExpired` after a cancel. The bench watches both across the whole timeout window. Step-engine faults show up as a wrong pulse count, a wrong pulse width or wrong spacing, or a `seekDone` early or late by an interval. These are visible within one seek.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

  typedef enum logic [1:0] {
    HD_IDLE,
    HD_SETTLING,
    HD_HELD,
    HD_TIMEOUT
  } head_st_e;

  typedef struct packed {
    logic headLoadStart;
    logic headUnloadStart;
    logic headCancel;
    logic seekStart;
    logic stepFire;
  } fdt_strobe_t;

  localparam int unsigned STEP_BASE   = 1;
  localparam int unsigned LOAD_BASE   = 2;
  localparam int unsigned UNLOAD_BASE = 16;

  // Ticks per code unit for the given rate, from the 2 Mb/s base value.
  function automatic int unsigned rateUnit(input int unsigned base2m, input logic [2:0] rate);
    case (rate)
      3'd0:    return base2m;
      3'd1:    return base2m * 2;
      3'd2:    return base2m * 4;
      3'd3:    return (base2m * 20 + 1) / 3;
      default: return base2m * 8;
    endcase
  endfunction

endpackage

// File: rtl/fdt_datapath.sv
module fdt_datapath
  import fdt_pkg::*;
#(
  parameter int CLK_PER_QMS = 4,
  parameter int PULSE_W     = 2,
  parameter int STEPS_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         rateSel,
  input  logic               specWr,
  input  logic [3:0]         specSrt,
  input  logic [3:0]         specHut,
  input  logic [6:0]         specHlt,
  input  logic [STEPS_W-1:0] seekSteps,
  input  fdt_strobe_t        stb,
  output logic               headExpire,
  output logic               stepExpire,
  output logic               stepsZero,
  output logic               stepOut
);

  localparam int MAX_CLKS = 2048 * CLK_PER_QMS;
  localparam int CNT_W    = $clog2(MAX_CLKS + 1);
  localparam int WID_W    = $clog2(PULSE_W + 1);
  localparam int unsigned CPQ = CLK_PER_QMS;

  logic [3:0]         srtQ, hutQ;
  logic [6:0]         hltQ;
  logic [CNT_W-1:0]   headCnt, intCnt;
  logic [CNT_W-1:0]   loadClks, unloadClks, stepClks;
  logic [STEPS_W-1:0] stepsLeft;
  logic [WID_W-1:0]   widthCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srtQ <= '0;
      hutQ <= '0;
      hltQ <= '0;
    end else if (specWr) begin
      srtQ <= specSrt;
      hutQ <= specHut;
      hltQ <= specHlt;
    end
  end

  always_comb begin
    int unsigned hltEff, hutEff, srtEff;
    hltEff = (hltQ == 7'd0) ? 32'd128 : {25'd0, hltQ};
    hutEff = (hutQ == 4'd0) ? 32'd16  : {28'd0, hutQ};
    srtEff = 32'd16 - {28'd0, srtQ};
    loadClks   = CNT_W'(hltEff * rateUnit(LOAD_BASE, rateSel) * CPQ);
    unloadClks = CNT_W'(hutEff * rateUnit(UNLOAD_BASE, rateSel) * CPQ);
    stepClks   = CNT_W'(srtEff * rateUnit(STEP_BASE, rateSel) * CPQ);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headCnt <= '0;
    end else if (stb.headCancel) begin
      headCnt <= '0;
    end else if (stb.headLoadStart) begin
      headCnt <= loadClks;
    end else if (stb.headUnloadStart) begin
      headCnt <= unloadClks;
    end else if (headCnt != '0) begin
      headCnt <= headCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intCnt <= '0;
    end else if (stb.stepFire) begin
      intCnt <= stepClks;
    end else if (intCnt != '0) begin
      intCnt <= intCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stepsLeft <= '0;
    end else if (stb.seekStart) begin
      stepsLeft <= seekSteps - 1'b1;
    end else if (stb.stepFire && stepsLeft != '0) begin
      stepsLeft <= stepsLeft - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stepOut  <= 1'b0;
      widthCnt <= '0;
    end else if (stb.stepFire) begin
      stepOut  <= 1'b1;
      widthCnt <= WID_W'(PULSE_W - 1);
    end else if (stepOut) begin
      if (widthCnt == '0) stepOut <= 1'b0;
      else                widthCnt <= widthCnt - 1'b1;
    end
  end

  assign headExpire = (headCnt == CNT_W'(1));
  assign stepExpire = (intCnt == CNT_W'(1));
  assign stepsZero  = (stepsLeft == '0);

endmodule

// File: rtl/fdt_ctrl.sv
module fdt_ctrl
  import fdt_pkg::*;
#(
  parameter int STEPS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seekReq,
  input  logic [STEPS_W-1:0] seekSteps,
  input  logic               loadReq,
  input  logic               execEnd,
  input  logic               headExpire,
  input  logic               stepExpire,
  input  logic               stepsZero,
  output fdt_strobe_t        stb,
  output logic               seekBusy,
  output logic               seekDone,
  output logic               headLoaded,
  output logic               loadDone,
  output logic               unloadExpired,
  output logic               pollInhibit
);

  head_st_e headSt, headNext;
  logic     seekAccept, seekEmpty, seekLast, loadDoneNext, unloadNext;

  assign seekAccept = seekReq && !seekBusy;
  assign seekEmpty  = seekAccept && (seekSteps == '0);
  assign seekLast   = seekBusy && stepExpire && stepsZero;

  always_comb begin
    stb              = '0;
    stb.seekStart    = seekAccept && !seekEmpty;
    stb.stepFire     = stb.seekStart || (seekBusy && stepExpire && !stepsZero);
    headNext         = headSt;
    loadDoneNext     = 1'b0;
    unloadNext       = 1'b0;
    case (headSt)
      HD_IDLE: begin
        if (loadReq) begin
          stb.headLoadStart = 1'b1;
          headNext          = HD_SETTLING;
        end
      end
      HD_SETTLING: begin
        if (headExpire) begin
          loadDoneNext = 1'b1;
          headNext     = HD_HELD;
        end
      end
      HD_HELD: begin
        if (loadReq) begin
          loadDoneNext = 1'b1;
        end else if (execEnd) begin
          stb.headUnloadStart = 1'b1;
          headNext            = HD_TIMEOUT;
        end
      end
      HD_TIMEOUT: begin
        if (loadReq) begin
          stb.headCancel = 1'b1;
          loadDoneNext   = 1'b1;
          headNext       = HD_HELD;
        end else if (execEnd) begin
          stb.headUnloadStart = 1'b1;
        end else if (headExpire) begin
          unloadNext = 1'b1;
          headNext   = HD_IDLE;
        end
      end
      default: headNext = HD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headSt        <= HD_IDLE;
      loadDone      <= 1'b0;
      unloadExpired <= 1'b0;
      seekBusy      <= 1'b0;
      seekDone      <= 1'b0;
    end else begin
      headSt        <= headNext;
      loadDone      <= loadDoneNext;
      unloadExpired <= unloadNext;
      seekDone      <= seekEmpty || seekLast;
      if (stb.seekStart)  seekBusy <= 1'b1;
      else if (seekLast)  seekBusy <= 1'b0;
    end
  end

  assign headLoaded  = (headSt != HD_IDLE);
  assign pollInhibit = headLoaded;

endmodule

// File: rtl/fdd_delay_timer.sv
module fdd_delay_timer
  import fdt_pkg::*;
#(
  parameter int CLK_PER_QMS = 4,
  parameter int PULSE_W     = 2,
  parameter int STEPS_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         rateSel,
  input  logic               specWr,
  input  logic [3:0]         specSrt,
  input  logic [3:0]         specHut,
  input  logic [6:0]         specHlt,
  input  logic               seekReq,
  input  logic [STEPS_W-1:0] seekSteps,
  input  logic               loadReq,
  input  logic               execEnd,
  output logic               stepOut,
  output logic               seekBusy,
  output logic               seekDone,
  output logic               headLoaded,
  output logic               loadDone,
  output logic               unloadExpired,
  output logic               pollInhibit
);

  fdt_strobe_t stb;
  logic        headExpire, stepExpire, stepsZero;

  fdt_ctrl #(.STEPS_W(STEPS_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .seekReq(seekReq), .seekSteps(seekSteps),
    .loadReq(loadReq), .execEnd(execEnd), .headExpire(headExpire),
    .stepExpire(stepExpire), .stepsZero(stepsZero), .stb(stb),
    .seekBusy(seekBusy), .seekDone(seekDone), .headLoaded(headLoaded),
    .loadDone(loadDone), .unloadExpired(unloadExpired), .pollInhibit(pollInhibit)
  );

  fdt_datapath #(.CLK_PER_QMS(CLK_PER_QMS), .PULSE_W(PULSE_W), .STEPS_W(STEPS_W)) uPath (
    .clk(clk), .rst_n(rst_n), .rateSel(rateSel), .specWr(specWr),
    .specSrt(specSrt), .specHut(specHut), .specHlt(specHlt),
    .seekSteps(seekSteps), .stb(stb), .headExpire(headExpire),
    .stepExpire(stepExpire), .stepsZero(stepsZero), .stepOut(stepOut)
  );

endmodule

// File: rtl/fdt_checker.sv
module fdt_checker #(
  parameter int PULSE_W = 2
) (
  input logic clk,
  input logic rst_n,
  input logic loadReq,
  input logic stepOut,
  input logic seekBusy,
  input logic seekDone,
  input logic headLoaded,
  input logic loadDone,
  input logic unloadExpired
);

  logic [7:0] hiCnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  hiCnt <= '0;
    else if (!stepOut)           hiCnt <= '0;
    else if (hiCnt != 8'hFF)     hiCnt <= hiCnt + 1'b1;
  end

  AST_STEP_IN_SEEK: assert property (@(posedge clk) disable iff (!rst_n)
    stepOut |-> seekBusy); // R4

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    stepOut |-> (hiCnt < 8'(PULSE_W))); // R5

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    seekDone |-> !seekBusy); // R6

  AST_LOAD_FROM_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(headLoaded) |-> $past(loadReq)); // R8

  AST_SETTLED_WHILE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    loadDone |-> headLoaded); // R8

  AST_EXPIRY_DROPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    unloadExpired |-> (!headLoaded && $past(headLoaded))); // R9

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(loadDone && unloadExpired)); // R10

endmodule

bind fdd_delay_timer fdt_checker #(.PULSE_W(PULSE_W)) uChk (
  .clk(clk), .rst_n(rst_n), .loadReq(loadReq), .stepOut(stepOut),
  .seekBusy(seekBusy), .seekDone(seekDone), .headLoaded(headLoaded),
  .loadDone(loadDone), .unloadExpired(unloadExpired)
);

// File: tb/tb_fdd_delay_timer.sv
module tb_fdd_delay_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CPQ        = 4;
  localparam int PW         = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rateSel = '0;
  logic       specWr = 1'b0;
  logic [3:0] specSrt = '0, specHut = '0;
  logic [6:0] specHlt = '0;
  logic       seekReq = 1'b0;
  logic [7:0] seekSteps = '0;
  logic       loadReq = 1'b0, execEnd = 1'b0;
  logic       stepOut, seekBusy, seekDone, headLoaded, loadDone, unloadExpired, pollInhibit;

  int checks = 0, fails = 0, lastN = 0;
  int curSrt = 0, curHut = 0, curHlt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fdd_delay_timer #(.CLK_PER_QMS(CPQ), .PULSE_W(PW), .STEPS_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .rateSel(rateSel), .specWr(specWr),
    .specSrt(specSrt), .specHut(specHut), .specHlt(specHlt),
    .seekReq(seekReq), .seekSteps(seekSteps), .loadReq(loadReq),
    .execEnd(execEnd), .stepOut(stepOut), .seekBusy(seekBusy),
    .seekDone(seekDone), .headLoaded(headLoaded), .loadDone(loadDone),
    .unloadExpired(unloadExpired), .pollInhibit(pollInhibit)
  );

  function automatic int stepU(int r);
    case (r) 0: return 1; 1: return 2; 2: return 4; 3: return 7; default: return 8; endcase
  endfunction
  function automatic int loadU(int r);
    case (r) 0: return 2; 1: return 4; 2: return 8; 3: return 13; default: return 16; endcase
  endfunction
  function automatic int unloadU(int r);
    case (r) 0: return 16; 1: return 32; 2: return 64; 3: return 107; default: return 128; endcase
  endfunction
  function automatic int expLoad(int r, int h);
    return ((h == 0) ? 128 : h) * loadU(r) * CPQ;
  endfunction
  function automatic int expUnload(int r, int h);
    return ((h == 0) ? 16 : h) * unloadU(r) * CPQ;
  endfunction
  function automatic int expStep(int r, int s);
    return (16 - s) * stepU(r) * CPQ;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic doSpec(input int s, input int h, input int l);
    @(negedge clk);
    specWr = 1'b1; specSrt = 4'(s); specHut = 4'(h); specHlt = 7'(l);
    @(negedge clk);
    specWr = 1'b0;
    curSrt = s; curHut = h; curHlt = l;
  endtask

  task automatic runLoad(input int r, input bit poke);
    int exp = expLoad(r, curHlt);
    int n = 0;
    @(negedge clk); rateSel = 3'(r); loadReq = 1'b1;
    @(negedge clk); loadReq = 1'b0;
    check(headLoaded == 1'b1, "R8", "headLoaded after request", int'(headLoaded), 1);
    check(pollInhibit == 1'b1, "R11", "pollInhibit while loaded", int'(pollInhibit), 1);
    while (!loadDone && n < exp + 4) begin
      if (poke && n == 2) begin loadReq = 1'b1; execEnd = 1'b1; specWr = 1'b1; specHlt = 7'd1; end
      if (poke && n == 3) begin loadReq = 1'b0; execEnd = 1'b0; specWr = 1'b0; curHlt = 1; end
      @(negedge clk); n++;
    end
    lastN = n;
    check(n == exp, "R8", "settle delay", n, exp);
    if (poke) begin
      check(n == exp, "R12", "settle delay with extra requests", n, exp);
      check(n == exp, "R2", "settle delay after mid-run code write", n, exp);
    end
  endtask

  task automatic runUnload(input int r);
    int exp = expUnload(r, curHut);
    int n = 0, dropped = 0;
    @(negedge clk); rateSel = 3'(r); execEnd = 1'b1;
    @(negedge clk); execEnd = 1'b0;
    while (!unloadExpired && n < exp + 4) begin
      if (!headLoaded) dropped++;
      @(negedge clk); n++;
    end
    lastN = n;
    check(n == exp, "R9", "unload timeout", n, exp);
    check(dropped == 0, "R9", "early head drop cycles", dropped, 0);
    check(headLoaded == 1'b0, "R9", "headLoaded at expiry", int'(headLoaded), 0);
    check(pollInhibit == 1'b0, "R11", "pollInhibit after unload", int'(pollInhibit), 0);
  endtask

  task automatic runSeek(input int r, input int steps, input bit poke);
    int s = expStep(r, curSrt);
    int n = 0, rises = 0, highs = 0, badSpace = 0, doneAt = -1;
    bit prev = 1'b0;
    @(negedge clk); rateSel = 3'(r); seekSteps = 8'(steps); seekReq = 1'b1;
    @(negedge clk); seekReq = 1'b0;
    if (steps > 0) check(seekBusy == 1'b1, "R6", "seekBusy during seek", int'(seekBusy), 1);
    while (n <= steps * s + 4) begin
      if (stepOut && !prev) begin
        if (n != rises * s) badSpace++;
        rises++;
      end
      if (stepOut) highs++;
      prev = stepOut;
      if (seekDone) begin doneAt = n; break; end
      if (poke && n == 1) begin seekReq = 1'b1; seekSteps = 8'd9; end
      if (poke && n == 2) seekReq = 1'b0;
      @(negedge clk); n++;
    end
    check(rises == steps, poke ? "R7" : "R4", "pulse count", rises, steps);
    check(badSpace == 0, "R4", "misplaced pulses", badSpace, 0);
    check(highs == steps * PW, "R5", "total pulse-high cycles", highs, steps * PW);
    check(doneAt == steps * s, "R6", "seekDone cycle", doneAt, steps * s);
    check(seekBusy == 1'b0, "R6", "seekBusy at done", int'(seekBusy), 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check({stepOut, seekBusy, seekDone, headLoaded, loadDone, unloadExpired, pollInhibit} == 7'b0,
          "R1", "outputs after reset",
          int'({stepOut, seekBusy, seekDone, headLoaded, loadDone, unloadExpired, pollInhibit}), 0);

    // R12: execEnd on an unloaded head is ignored
    begin
      int seen = 0;
      @(negedge clk); execEnd = 1'b1;
      @(negedge clk); execEnd = 1'b0;
      repeat (4) begin
        if (headLoaded || unloadExpired) seen++;
        @(negedge clk);
      end
      check(seen == 0, "R12", "activity after execEnd while unloaded", seen, 0);
    end

    // R1: zero codes after reset give the longest delays
    runLoad(0, 1'b0);
    check(lastN == 1024, "R1", "settle with reset code", lastN, 1024);
    runUnload(4);
    check(lastN == 8192, "R1", "unload with reset code", lastN, 8192);
    runSeek(4, 2, 1'b0);

    // Fastest step, longest settle code, short unload
    doSpec(15, 1, 127);
    runSeek(0, 5, 1'b0);
    runSeek(2, 0, 1'b0);
    runSeek(1, 3, 1'b1);
    runLoad(0, 1'b0);
    // R10: request while held gives immediate loadDone
    @(negedge clk); loadReq = 1'b1;
    @(negedge clk); loadReq = 1'b0;
    check(loadDone == 1'b1, "R10", "immediate loadDone when held", int'(loadDone), 1);
    runUnload(0);

    // R10: cancel of a running unload timeout; R12/R2 pokes during settle
    doSpec(15, 3, 127);
    runLoad(2, 1'b1);
    begin
      int bad = 0;
      int u = expUnload(2, 3);
      @(negedge clk); rateSel = 3'd2; execEnd = 1'b1;
      @(negedge clk); execEnd = 1'b0;
      repeat (5) @(negedge clk);
      loadReq = 1'b1;
      @(negedge clk); loadReq = 1'b0;
      check(loadDone == 1'b1, "R10", "loadDone on cancel", int'(loadDone), 1);
      repeat (u + 8) begin
        if (unloadExpired || !headLoaded) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R10", "unload after cancel", bad, 0);
    end
    // R9: restart of the timeout by a second execEnd
    @(negedge clk); execEnd = 1'b1;
    @(negedge clk); execEnd = 1'b0;
    repeat (10) @(negedge clk);
    runUnload(2);

    // R3: random codes across all rate encodings
    for (int i = 0; i < 6; i++) begin
      int r = int'($urandom_range(7, 0));
      doSpec(int'($urandom_range(15, 0)), int'($urandom_range(15, 0)), int'($urandom_range(127, 0)));
      runLoad(r, 1'b0);
      check(lastN == expLoad(r, curHlt), "R3", "settle at random rate", lastN, expLoad(r, curHlt));
      runSeek(r, int'($urandom_range(4, 0)), 1'b0);
      runUnload(r);
      check(lastN == expUnload(r, curHut), "R3", "unload at random rate", lastN, expUnload(r, curHut));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule